// File: doc/BRIEF.md
# Paced Multichannel Acquisition Sequencer

This block paces a converter that digitises several analog channels in turn. An internal divider produces a one-clock pulse at a fixed rate, 5 kHz by default. Each pulse opens an acquisition round. The sequencer raises its run request to the converter. It then handles each channel in turn: it waits for the converter's data-ready strobe, pulses a store enable for the sample register, pulses a compare enable for the window checker, and advances the channel index.

When the last channel is done, the run request drops and the index returns to zero. A converter that stays silent until the next period pulse ends the round early. In that case the sequencer raises a sticky error flag, drops the run request and clears the index, so the following round starts again from the first channel. The serial converter link and the window comparators sit outside this block. They are driven by its store and compare strobes and by the channel index.

Top module: `acq_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, run_acq, store_en, cmp_en and acq_err are 0 and chan_idx is 0.
- R2: Acquisition rounds start every DIV = CLK_HZ/RATE_HZ clock cycles, measured between consecutive rising edges of run_acq, provided each round finishes within one period.
- R3: run_acq rises in the cycle after a period pulse is seen while idle, and stays high until the round ends, through a timeout or after the last channel.
- R4: A data-ready pulse seen while waiting on channel k makes store_en high for one cycle in the following cycle and cmp_en high for one cycle right after. chan_idx equals k, 0-based, from the start of that wait through both strobes, and becomes k+1 two cycles after cmp_en.
- R5: After NUM_CH channels, run_acq is 0 one cycle after chan_idx reaches NUM_CH, and chan_idx is 0 the cycle after that.
- R6: If a period pulse arrives before data-ready while waiting, run_acq falls and acq_err rises in the same cycle. If no data-ready comes at all, run_acq is then high for exactly DIV cycles. chan_idx is 0 one cycle after run_acq falls.
- R7: Once set, acq_err stays 1 through later complete rounds and clears only on reset.
- R8: data-ready while no round is running is ignored: no store_en or cmp_en pulse, and chan_idx stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_ready | input | 1 | Converter data-ready strobe |
| run_acq | output | 1 | Run request to the converter, high for a whole round |
| store_en | output | 1 | One-cycle enable for the sample register of chan_idx |
| cmp_en | output | 1 | One-cycle enable for the window comparison of chan_idx |
| chan_idx | output | $clog2(NUM_CH+1) | Index of the channel being acquired, 0-based |
| acq_err | output | 1 | Sticky converter-timeout flag |

## Verification
A wrong state register shows up at the ports within one to four cycles. It appears as a store strobe without the compare that should follow, a compare arriving a cycle late, or run_acq dropping in the wrong cycle. A miscounting channel counter produces a round with the wrong number of store pulses, or an index that does not return to 0 after a timeout, and this is visible by the end of that round. A divider off by one moves round starts and the timeout length by one cycle. The bench measures these spacings exactly in every round.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_WAIT, S_TMO, S_STORE, S_CMP, S_INC, S_CHK, S_DONE
  } seq_state_t;
endpackage

// File: rtl/period_tick_gen.sv
module period_tick_gen #(
  parameter int DIV = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(DIV - 1);

  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/chan_counter.sv
module chan_counter #(
  parameter int NUM_CH = 5,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R5
  chan_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0));

  // R5
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(NUM_CH));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import acq_seq_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          adc_ready,
  input  logic [CW-1:0] chan,
  output logic          inc,
  output logic          clr,
  output logic          run_acq,
  output logic          store_en,
  output logic          cmp_en,
  output logic          acq_err
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (tick) state_d = S_START;
      S_START: state_d = S_WAIT;
      S_WAIT: begin
        if (adc_ready) state_d = S_STORE;
        else if (tick) state_d = S_TMO;
      end
      S_TMO:   state_d = S_IDLE;
      S_STORE: state_d = S_CMP;
      S_CMP:   state_d = S_INC;
      S_INC:   state_d = S_CHK;
      S_CHK:   state_d = (chan < CW'(NUM_CH)) ? S_WAIT : S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign inc = (state_q == S_INC);
  assign clr = (state_q == S_TMO) || (state_q == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      run_acq  <= 1'b0;
      store_en <= 1'b0;
      cmp_en   <= 1'b0;
      acq_err  <= 1'b0;
    end else begin
      state_q  <= state_d;
      run_acq  <= (state_d == S_START) || (state_d == S_WAIT) ||
                  (state_d == S_STORE) || (state_d == S_CMP)  ||
                  (state_d == S_INC)   || (state_d == S_CHK);
      store_en <= (state_d == S_STORE);
      cmp_en   <= (state_d == S_CMP);
      acq_err  <= acq_err || (state_d == S_TMO);
    end
  end

  // R4
  store_then_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    store_en |=> cmp_en && !store_en);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(store_en && cmp_en));

  // R8
  store_in_round_chk: assert property (@(posedge clk) disable iff (rst)
    store_en |-> run_acq);

  // R6
  err_rise_stops_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(acq_err) |-> !run_acq);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    acq_err |=> acq_err);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int RATE_HZ = 5000,
  parameter int NUM_CH  = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adc_ready,
  output logic                        run_acq,
  output logic                        store_en,
  output logic                        cmp_en,
  output logic [$clog2(NUM_CH+1)-1:0] chan_idx,
  output logic                        acq_err
);
  localparam int DIV = CLK_HZ / RATE_HZ;
  localparam int CW  = $clog2(NUM_CH + 1);

  logic tick, inc, clr;

  period_tick_gen #(.DIV(DIV)) u_tick (
    .clk (clk), .rst (rst), .tick (tick)
  );

  chan_counter #(.NUM_CH(NUM_CH), .CW(CW)) u_cnt (
    .clk (clk), .rst (rst), .inc (inc), .clr (clr), .cnt (chan_idx)
  );

  seq_fsm #(.NUM_CH(NUM_CH), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .adc_ready (adc_ready),
    .chan      (chan_idx),
    .inc       (inc),
    .clr       (clr),
    .run_acq   (run_acq),
    .store_en  (store_en),
    .cmp_en    (cmp_en),
    .acq_err   (acq_err)
  );
endmodule

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;
  localparam int CLK_HZ  = 200_000;
  localparam int RATE_HZ = 1000;
  localparam int NUM_CH  = 5;
  localparam int DIV     = CLK_HZ / RATE_HZ;
  localparam int CW      = $clog2(NUM_CH + 1);

  logic clk = 1'b0, rst = 1'b1, adc_ready = 1'b0;
  logic run_acq, store_en, cmp_en, acq_err;
  logic [CW-1:0] chan_idx;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acq_sequencer #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ), .NUM_CH(NUM_CH)) u_acq_sequencer (
    .clk(clk), .rst(rst), .adc_ready(adc_ready), .run_acq(run_acq),
    .store_en(store_en), .cmp_en(cmp_en), .chan_idx(chan_idx), .acq_err(acq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_rise(output int at);
    int n = 0;
    while (run_acq !== 1'b1 && n < 4 * DIV) begin @(negedge clk); n++; end
    chk(run_acq === 1'b1, "R3 round start", int'(run_acq), 1);
    at = cyc;
  endtask

  // Starts at the negedge where run_acq was first seen high.
  task automatic run_round(input int dly);
    @(negedge clk);
    chk(run_acq == 1'b1, "R3 run held", int'(run_acq), 1);
    for (int k = 0; k < NUM_CH; k++) begin
      chk(chan_idx == CW'(k), "R4 index in wait", int'(chan_idx), k);
      repeat (dly) @(negedge clk);
      adc_ready = 1'b1;
      @(negedge clk);
      adc_ready = 1'b0;
      chk(store_en && !cmp_en && chan_idx == CW'(k), "R4 store strobe", int'(store_en), 1);
      @(negedge clk);
      chk(cmp_en && !store_en && chan_idx == CW'(k), "R4 compare strobe", int'(cmp_en), 1);
      @(negedge clk);
      chk(!cmp_en && !store_en, "R4 strobes one cycle", int'(cmp_en), 0);
      @(negedge clk);
      chk(chan_idx == CW'(k + 1), "R4 index advance", int'(chan_idx), k + 1);
      @(negedge clk);
      if (k == NUM_CH - 1) begin
        chk(run_acq == 1'b0, "R5 run drops after last", int'(run_acq), 0);
        @(negedge clk);
        chk(chan_idx == '0, "R5 index zeroed", int'(chan_idx), 0);
      end else begin
        chk(run_acq == 1'b1, "R3 run held mid round", int'(run_acq), 1);
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({run_acq, store_en, cmp_en, acq_err} == 4'b0 && chan_idx == '0, "R1 in reset",
        int'({run_acq, store_en, cmp_en, acq_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({run_acq, store_en, cmp_en, acq_err} == 4'b0 && chan_idx == '0, "R1 after reset",
        int'({run_acq, store_en, cmp_en, acq_err}), 0);
  endtask

  task automatic t_rounds_and_period();
    int a, b;
    wait_rise(a);
    run_round(0);
    wait_rise(b);
    chk(b - a == DIV, "R2 period", b - a, DIV);
    run_round(3);
    wait_rise(a);
    chk(a - b == DIV, "R2 period after slow round", a - b, DIV);
    run_round(1);
    chk(acq_err == 1'b0, "R7 no error on good rounds", int'(acq_err), 0);
  endtask

  task automatic t_idle_ready();
    for (int i = 0; i < 6; i++) begin
      adc_ready = 1'b1;
      @(negedge clk);
      chk(!store_en && !cmp_en && chan_idx == '0 && !run_acq, "R8 ready ignored in idle",
          int'(store_en), 0);
    end
    adc_ready = 1'b0;
  endtask

  task automatic t_timeout(input int served);
    int a, n;
    wait_rise(a);
    @(negedge clk);
    for (int k = 0; k < served; k++) begin
      adc_ready = 1'b1;
      @(negedge clk);
      adc_ready = 1'b0;
      repeat (4) @(negedge clk);
    end
    n = 0;
    while (run_acq === 1'b1 && n < 2 * DIV) begin @(negedge clk); n++; end
    if (served == 0) chk(cyc - a == DIV, "R6 timeout length", cyc - a, DIV);
    chk(acq_err == 1'b1, "R6 error with run drop", int'(acq_err), 1);
    chk(chan_idx == CW'(served), "R6 index at timeout", int'(chan_idx), served);
    @(negedge clk);
    chk(chan_idx == '0, "R6 index cleared", int'(chan_idx), 0);
  endtask

  task automatic t_sticky();
    int a;
    wait_rise(a);
    run_round(0);
    chk(acq_err == 1'b1, "R7 error held over good round", int'(acq_err), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(acq_err == 1'b0, "R7 error cleared by reset", int'(acq_err), 0);
  endtask

  initial begin
    t_reset();
    t_rounds_and_period();
    t_idle_ready();
    t_timeout(0);
    t_timeout(2);
    t_sticky();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule